// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register File

This block holds the configuration state of an interrupt router behind a narrow 32-bit memory-mapped window. Software never addresses a register directly. It first writes an index into a select register, and then reads or writes the chosen register through a single data window. The index space holds four kinds of register:

- an identification register with a 4-bit writable ID;
- a read-only version register that reports the pin count and a version code;
- an arbitration register that always reads zero;
- a table of 64-bit routing entries, one per interrupt pin, with each entry split into two 32-bit halves at adjacent indices.

The table is the block's main storage. Every accepted write to a table half produces a one-cycle update pulse that carries the entry number, so that the logic scanning for pending interrupts re-evaluates the table. An access to an offset or an index that holds no register is harmless: it reads zero, its write is dropped, and it latches an error flag that stays set until reset.

A two-state controller paces the bus. In state IDLE, `ready_o` is high and a request is accepted. A write completes in the cycle it is accepted, and the controller stays in IDLE. An accepted read takes the transition IDLE→RESP. In RESP, `rvalid_o` presents the data for one cycle with `ready_o` low, and the transition RESP→IDLE is unconditional.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset the following hold: the select value is 0, the ID is 0, every routing entry's low half is 0x00010000 (mask bit 16 set) and its high half is 0, `err_o` is 0, `upd_o` is 0 and `ready_o` is 1.
- R2: Only `addr_i[7:0]` is decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Upper address bits have no effect.
- R3: A write to offset 0x00 stores `wdata_i[7:0]` as the select value. A read of offset 0x00 returns it in bits 7:0, with bits 31:8 zero.
- R4: Index 0x00 is the ID register. Its 4-bit ID reads in bits 27:24 and all other bits read 0. A write updates only those four bits, from `wdata_i[27:24]`.
- R5: Index 0x01 reads (NPINS-1) in bits 23:16 and VERSION in bits 3:0, with all other bits 0. Writes to it change nothing.
- R6: Index 0x02 reads 0 and ignores writes. Accesses to indices 0x01 and 0x02 do not set the error flag.
- R7: Index 0x10+2n addresses bits 31:0 of entry n, and index 0x11+2n addresses bits 63:32 of entry n, for n < NPINS. A write changes only the addressed half of the addressed entry.
- R8: `upd_o` is high for exactly the one cycle after each accepted entry write, with `upd_idx_o` = n. Writes to any other register produce no pulse.
- R9: Accessing an offset other than 0x00 or 0x10, or an undefined index (0x03 to 0x0F, or 0x10+2·NPINS and above), has three effects. A read returns 0, a write changes nothing, and `err_o` is set. `err_o` stays set until reset.
- R10: A request is accepted when `req_i` and `ready_o` are both high. An accepted read gives `rvalid_o` high with its data in the following cycle only, and `ready_o` is low in that cycle. A write leaves `ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address; only bits 7:0 are decoded |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Controller in IDLE; a request can be accepted |
| rvalid_o | output | 1 | Read data valid (state RESP) |
| rdata_o | output | 32 | Read data |
| upd_o | output | 1 | One-cycle table-update pulse |
| upd_idx_o | output | $clog2(NPINS) | Entry number of the write that caused the pulse |
| err_o | output | 1 | Sticky access-error flag |

## Verification
The hardest property to reach is the separation of the two error causes. Because the flag is sticky, the first bad access hides every later one. The bench therefore resets the block a second time so that a bad offset and an undefined index each start from a clear flag. It also shows that a dropped write to a bad offset leaves the select value untouched, by reading the select value back afterwards. Table boundaries are reached by writing both halves of the last entry and then probing the first index past it. Neighbouring halves are read back to show that each write hit only its own word.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [2:0] {
        RG_SEL,
        RG_ID,
        RG_VER,
        RG_ARB,
        RG_ENT,
        RG_BAD
    } region_e;

    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;
    localparam logic [7:0] IDX_ID     = 8'h00;
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam logic [7:0] IDX_ARB    = 8'h02;
    localparam logic [7:0] IDX_TABLE  = 8'h10;
    localparam logic [31:0] ENT_LO_RESET = 32'h0001_0000;

endpackage

// File: rtl/irq_rf_decode.sv
module irq_rf_decode
    import irq_rf_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [7:0]    offset_i,
    input  logic [7:0]    sel_i,
    output region_e       region_o,
    output logic [IW-1:0] ent_idx_o,
    output logic          ent_hi_o
);

    logic [7:0] rel;
    logic [6:0] idx7;

    always_comb begin
        rel       = sel_i - IDX_TABLE;
        idx7      = rel[7:1];
        ent_idx_o = idx7[IW-1:0];
        ent_hi_o  = sel_i[0];
        region_o  = RG_BAD;
        if (offset_i == OFF_SELECT) begin
            region_o = RG_SEL;
        end else if (offset_i == OFF_WINDOW) begin
            if (sel_i == IDX_ID)       region_o = RG_ID;
            else if (sel_i == IDX_VER) region_o = RG_VER;
            else if (sel_i == IDX_ARB) region_o = RG_ARB;
            else if (sel_i >= IDX_TABLE && int'(idx7) < NPINS)
                                       region_o = RG_ENT;
        end
    end

endmodule

// File: rtl/irq_rf_table.sv
module irq_rf_table
    import irq_rf_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] idx_i,
    input  logic          hi_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o
);

    logic [31:0] lo_q [NPINS];
    logic [31:0] hi_q [NPINS];

    for (genvar g = 0; g < NPINS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[g] <= ENT_LO_RESET;
                hi_q[g] <= '0;
            end else if (wr_en_i && idx_i == IW'(g)) begin
                if (hi_i) hi_q[g] <= wdata_i;
                else      lo_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = hi_i ? hi_q[idx_i] : lo_q[idx_i];

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_rf_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [3:0] VERSION = 4'h1,
    localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [31:0]   addr_i,
    input  logic [31:0]   wdata_i,
    output logic          ready_o,
    output logic          rvalid_o,
    output logic [31:0]   rdata_o,
    output logic          upd_o,
    output logic [IW-1:0] upd_idx_o,
    output logic          err_o
);

    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    bus_state_e    state_q, state_d;
    region_e       region;
    logic [IW-1:0] ent_idx;
    logic          ent_hi;
    logic [7:0]    sel_q;
    logic [3:0]    id_q;
    logic [31:0]   tbl_word, rd_word, rdata_q;
    logic          acc, wr_acc, rd_acc;

    irq_rf_decode #(.NPINS(NPINS)) u_dec (
        .offset_i (addr_i[7:0]),
        .sel_i    (sel_q),
        .region_o (region),
        .ent_idx_o(ent_idx),
        .ent_hi_o (ent_hi)
    );

    assign acc    = req_i && (state_q == ST_IDLE);
    assign wr_acc = acc && we_i;
    assign rd_acc = acc && !we_i;

    irq_rf_table #(.NPINS(NPINS)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_acc && region == RG_ENT),
        .idx_i  (ent_idx),
        .hi_i   (ent_hi),
        .wdata_i(wdata_i),
        .rdata_o(tbl_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: IDLE->RESP on accepted read, RESP->IDLE always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_acc) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // read mux
    always_comb begin
        rd_word = '0;
        unique case (region)
            RG_SEL: rd_word = {24'h0, sel_q};
            RG_ID:  rd_word = {4'h0, id_q, 24'h0};
            RG_VER: rd_word = {8'h0, MAX_PIN, 12'h0, VERSION};
            RG_ENT: rd_word = tbl_word;
            RG_ARB, RG_BAD: rd_word = '0;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            id_q      <= '0;
            rdata_q   <= '0;
            upd_o     <= 1'b0;
            upd_idx_o <= '0;
            err_o     <= 1'b0;
        end else begin
            upd_o <= wr_acc && region == RG_ENT;
            if (wr_acc && region == RG_ENT) upd_idx_o <= ent_idx;
            if (wr_acc && region == RG_SEL) sel_q <= wdata_i[7:0];
            if (wr_acc && region == RG_ID)  id_q  <= wdata_i[27:24];
            if (rd_acc) rdata_q <= rd_word;
            if (acc && region == RG_BAD) err_o <= 1'b1;
        end
    end

    assign ready_o  = (state_q == ST_IDLE);
    assign rvalid_o = (state_q == ST_RESP);
    assign rdata_o  = rvalid_o ? rdata_q : '0;

endmodule

// File: rtl/irq_rf_checker.sv
module irq_rf_checker (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic we_i,
    input logic ready_o,
    input logic rvalid_o,
    input logic upd_o,
    input logic err_o
);

    // R8: a pulse only follows an accepted write
    a_r8_upd_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(req_i && we_i && ready_o));

    // R9: the error flag never clears without reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R10: read data only follows an accepted read
    a_r10_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(req_i && !we_i && ready_o));

    // R10: not ready while a response is presented
    a_r10_busy_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> !ready_o);

    // R10: a response lasts a single cycle
    a_r10_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

    // R10: an accepted write leaves the controller ready
    a_r10_write_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && ready_o) |=> ready_o);

endmodule

bind irq_route_regfile irq_rf_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .we_i    (we_i),
    .ready_o (ready_o),
    .rvalid_o(rvalid_o),
    .upd_o   (upd_o),
    .err_o   (err_o)
);

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb;

    localparam int         NP  = 24;
    localparam logic [3:0] VER = 4'h3;
    localparam int         IW  = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0, we_i = 1'b0;
    logic [31:0]   addr_i = '0, wdata_i = '0;
    logic          ready_o, rvalid_o, upd_o, err_o;
    logic [31:0]   rdata_o;
    logic [IW-1:0] upd_idx_o;

    int checks = 0, errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    irq_route_regfile #(.NPINS(NP), .VERSION(VER)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o),
        .rvalid_o(rvalid_o), .rdata_o(rdata_o), .upd_o(upd_o),
        .upd_idx_o(upd_idx_o), .err_o(err_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data when a response appears
    always @(negedge clk) begin
        if (rst_n && rvalid_o) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: actual unexpected rvalid expected none");
            end else begin
                check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
                check("R10 ready low in response", 32'(ready_o), 32'd0);
            end
        end
    end

    task automatic wait_ready();
        while (!ready_o) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d,
                      input bit exp_upd, input int exp_idx, input string tag);
        wait_ready();
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk); @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        check({tag, " upd pulse"}, 32'(upd_o), 32'(exp_upd));
        if (exp_upd) check({tag, " upd idx"}, 32'(upd_idx_o), 32'(exp_idx));
        check("R10 ready after write", 32'(ready_o), 32'd1);
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        wait_ready();
        exp_q.push_back(exp); tag_q.push_back(tag);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        @(posedge clk); @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        check({tag, " no upd on read"}, 32'(upd_o), 32'd0);
    endtask

    task automatic rd_idx(input logic [7:0] idx, input logic [31:0] exp, input string tag);
        wr(32'h0, {24'h0, idx}, 1'b0, 0, "R3 select");
        rd(32'h10, exp, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 err", 32'(err_o), 32'd0);
        check("R1 upd", 32'(upd_o), 32'd0);
        check("R1 ready", 32'(ready_o), 32'd1);
        rd(32'h0, 32'h0, "R1 select reset");
        rd(32'h10, 32'h0, "R1 id reset");
        rd_idx(8'h10, 32'h0001_0000, "R1 entry0 low reset");
        rd_idx(8'h3F, 32'h0, "R1 last entry high reset");

        // R3 select readback, R2 upper address bits ignored
        wr(32'h0, 32'hABCD_EF2C, 1'b0, 0, "R3 select write");
        rd(32'h0, 32'h0000_002C, "R3 select readback");
        rd(32'hFEC0_0000, 32'h0000_002C, "R2 upper bits ignored select");

        // R4 ID
        wr(32'h0, 32'h0, 1'b0, 0, "R3 select");
        wr(32'h10, 32'hFFFF_FFFF, 1'b0, 0, "R4 id write");
        rd(32'h10, 32'h0F00_0000, "R4 id readback");
        wr(32'h10, 32'h05FF_FFFF, 1'b0, 0, "R4 id write2");
        rd(32'hFEC0_0010, 32'h0500_0000, "R2 R4 window via upper bits");

        // R5 version, R6 arbitration
        rd_idx(8'h01, {8'h0, 8'(NP - 1), 12'h0, VER}, "R5 version read");
        wr(32'h10, 32'hFFFF_FFFF, 1'b0, 0, "R5 version write");
        rd(32'h10, {8'h0, 8'(NP - 1), 12'h0, VER}, "R5 version unchanged");
        rd_idx(8'h02, 32'h0, "R6 arb read");
        wr(32'h10, 32'hFFFF_FFFF, 1'b0, 0, "R6 arb write");
        rd(32'h10, 32'h0, "R6 arb unchanged");
        check("R6 no error", 32'(err_o), 32'd0);

        // R7 / R8 entries
        wr(32'h0, 32'h1A, 1'b0, 0, "R3 select");
        wr(32'h10, 32'h1234_5678, 1'b1, 5, "R8 entry5 low");
        wr(32'h0, 32'h1B, 1'b0, 0, "R3 select");
        wr(32'h10, 32'h9ABC_DEF0, 1'b1, 5, "R8 entry5 high");
        rd_idx(8'h1A, 32'h1234_5678, "R7 entry5 low");
        rd_idx(8'h1B, 32'h9ABC_DEF0, "R7 entry5 high");
        rd_idx(8'h18, 32'h0001_0000, "R7 entry4 low untouched");
        rd_idx(8'h1D, 32'h0, "R7 entry6 high untouched");
        wr(32'h0, 32'h3E, 1'b0, 0, "R3 select");
        wr(32'h10, 32'h0000_0031, 1'b1, NP - 1, "R8 last entry low");
        wr(32'h0, 32'h3F, 1'b0, 0, "R3 select");
        wr(32'h10, 32'hFF00_0000, 1'b1, NP - 1, "R8 last entry high");
        rd_idx(8'h3E, 32'h0000_0031, "R7 last entry low");
        rd_idx(8'h3F, 32'hFF00_0000, "R7 last entry high");
        check("R9 no error yet", 32'(err_o), 32'd0);

        // R9 undefined index past table
        rd_idx(8'h40, 32'h0, "R9 undefined index read");
        check("R9 err set by index", 32'(err_o), 32'd1);
        wr(32'h10, 32'h5555_5555, 1'b0, 0, "R9 undefined index write");
        rd(32'h0, 32'h0000_0040, "R9 select kept");
        check("R9 err sticky", 32'(err_o), 32'd1);

        // R9 bad offset after fresh reset
        do_reset();
        check("R1 err cleared", 32'(err_o), 32'd0);
        rd_idx(8'h1A, 32'h0001_0000, "R1 entry restored");
        wr(32'h0, 32'h11, 1'b0, 0, "R3 select");
        wr(32'h08, 32'h0000_0077, 1'b0, 0, "R9 bad offset write");
        check("R9 err set by offset", 32'(err_o), 32'd1);
        rd(32'h04, 32'h0, "R9 bad offset read");
        rd(32'h0, 32'h0000_0011, "R9 select unchanged");
        rd(32'h10, 32'h0, "R9 entry0 high unchanged");
        do_reset();
        rd_idx(8'h05, 32'h0, "R9 index 05 reads 0");
        check("R9 err by low undefined index", 32'(err_o), 32'd1);

        repeat (3) @(negedge clk);
        check("R10 all responses seen", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule